// File: doc/BRIEF.md
# Clocked serial transmit channel

This block sends one 8-bit character at a time over a two-wire clocked serial link made of a data line and a shift clock. A CPU-side write strobe loads the character. The data line then carries it least significant bit first. A new bit is presented on each active edge of the shift clock. The clock can come from either end of the link. In master role the channel divides the system clock and drives the shift clock on its own pin. In slave role it listens to an external clock and steps through the character when that clock moves.

A single control input chooses which edge of the shift clock is active. When the eighth bit's period closes, the channel raises a sticky completion flag and a one-cycle interrupt pulse. A write that arrives during a transfer is dropped and flagged as an error, so the character being sent is never disturbed.

Top module: `sio_tx`

## Requirements
- R1: A transfer presents exactly 8 bits on `txd`, least significant bit first. Bit 0 appears on `txd` in the cycle after the accepted write. Each later bit replaces the previous one at an active shift-clock edge.
- R2: With `clk_out_mode`=1, a write while idle starts a transfer and `sclk_oe` is 1. `sclk_out` toggles every D system cycles, where D is `div_half`, or 1 when `div_half` is 0. A transfer has 16 toggles, and `busy` stays high for exactly 16·D cycles.
- R3: `edge_fall`=0 makes the rising edge active, and the clock rests high while idle. `edge_fall`=1 makes the falling edge active, and the clock rests low while idle. `txd` changes only at active edges while busy.
- R4: With `clk_out_mode`=0, `sclk_oe` is 0. The character must be written before the external clock `sclk_in` starts. `sclk_in` passes through a two-flop synchronizer, and each active edge of the synchronized clock advances one bit.
- R5: The 8th active edge ends the transfer. In that same cycle `busy` falls, `done_flag` rises and `irq` is high for exactly one cycle.
- R6: `done_flag` stays set until `clr_flag` is pulsed or a new character is written.
- R7: A write while `busy` is high is ignored and sets `wr_err`. The character in flight completes unchanged. `clr_flag` clears `wr_err`.
- R8: After reset, `txd` is 1, `busy`, `done_flag`, `wr_err` and `irq` are 0, and `sclk_out` is at the idle level. When idle, `txd` holds the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Character to send |
| clr_flag | input | 1 | Clears done and error flags |
| clk_out_mode | input | 1 | 1: drive shift clock, 0: follow `sclk_in` |
| edge_fall | input | 1 | 0: rising active edge, 1: falling |
| div_half | input | DIVW | Shift clock half-period in system cycles |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Output enable for the clock pin |
| txd | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky completion flag |
| wr_err | output | 1 | Sticky write-while-busy error |
| irq | output | 1 | One-cycle transmit-done pulse |

## Verification
The bench sends random characters in both clock roles and with both edge choices. A reversed bit order, a wrong idle level or a wrong active edge therefore shows up as a wrong captured character. In master role it also varies the divider, including 0 and 1, and counts the busy cycles, which separates a correct half-period from an off-by-one. Directed cases write a different character mid-transfer to show that the frame is unharmed and the error is flagged. They also check that the done flag survives idle time and clears only on `clr_flag` or a new write.

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            clr_flag,
  input  logic            clk_out_mode,
  input  logic            edge_fall,
  input  logic [DIVW-1:0] div_half,
  input  logic            sclk_in,
  output logic            sclk_out,
  output logic            sclk_oe,
  output logic            txd,
  output logic            busy,
  output logic            done_flag,
  output logic            wr_err,
  output logic            irq
);
  localparam logic [DIVW-1:0] ONE = DIVW'(1);

  logic [7:0]      sh;
  logic [2:0]      bcnt;
  logic [DIVW-1:0] hcnt;
  logic            sclk_r;
  logic [1:0]      sync;
  logic            sync_d;

  wire             idle_lvl = ~edge_fall;
  wire [DIVW-1:0]  div_eff  = (div_half == '0) ? ONE : div_half;
  wire             hc_end   = (hcnt == div_eff - ONE);
  wire             int_act  = clk_out_mode & busy & hc_end & (sclk_r != idle_lvl);
  wire             ext_rise = sync[1] & ~sync_d;
  wire             ext_fall = ~sync[1] & sync_d;
  wire             ext_act  = ~clk_out_mode & busy & (edge_fall ? ext_fall : ext_rise);
  wire             act      = int_act | ext_act;
  wire             start    = wr_en & ~busy;

  assign sclk_out = busy ? sclk_r : idle_lvl;
  assign sclk_oe  = clk_out_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b00;
      sync_d <= 1'b0;
    end else begin
      sync   <= {sync[0], sclk_in};
      sync_d <= sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bcnt      <= '0;
      hcnt      <= '0;
      sclk_r    <= 1'b1;
      busy      <= 1'b0;
      txd       <= 1'b1;
      done_flag <= 1'b0;
      wr_err    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (clr_flag) begin
        done_flag <= 1'b0;
        wr_err    <= 1'b0;
      end
      if (wr_en && busy) wr_err <= 1'b1;
      if (start) begin
        sh        <= wr_data;
        txd       <= wr_data[0];
        bcnt      <= '0;
        hcnt      <= '0;
        sclk_r    <= idle_lvl;
        busy      <= 1'b1;
        done_flag <= 1'b0;
      end else if (busy) begin
        if (clk_out_mode) begin
          if (hc_end) begin
            hcnt   <= '0;
            sclk_r <= ~sclk_r;
          end else begin
            hcnt <= hcnt + ONE;
          end
        end
        if (act) begin
          if (bcnt == 3'd7) begin
            busy      <= 1'b0;
            done_flag <= 1'b1;
            irq       <= 1'b1;
          end else begin
            bcnt <= bcnt + 3'd1;
            sh   <= sh >> 1;
            txd  <= sh[1];
          end
        end
      end
    end
  end

  p_err_on_busy_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wr_err);
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);
  p_end_with_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  p_txd_moves_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !act) |=> $stable(txd));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(txd));
endmodule

// File: tb/sim_sio_tx.sv
module sim_sio_tx;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, clr_flag = 0, clk_out_mode = 1, edge_fall = 0, sclk_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] div_half = 1;
  logic sclk_out, sclk_oe, txd, busy, done_flag, wr_err, irq;
  int checks = 0, fails = 0, irq_cnt = 0;

  sio_tx #(.DIVW(8)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr_flag(clr_flag), .clk_out_mode(clk_out_mode), .edge_fall(edge_fall),
    .div_half(div_half), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .txd(txd), .busy(busy), .done_flag(done_flag), .wr_err(wr_err), .irq(irq));

  always #4 clk = ~clk;
  always @(negedge clk) if (irq) irq_cnt++;

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_div(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic xfer_out(input logic [7:0] d, input bit ef, input logic [7:0] dv, input bit inject);
    logic [7:0] got = 0;
    int nb = 0, bcyc = 0, i0 = irq_cnt;
    logic idl = ~ef;
    logic prev = idl;
    int lim = 16 * eff_div(dv) + 6;
    @(negedge clk);
    clk_out_mode = 1; edge_fall = ef; div_half = dv;
    @(negedge clk);
    chk(sclk_out == idl, "R3 idle level", sclk_out, idl);
    wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk(txd == d[0], "R1 first bit", txd, d[0]);
    chk(sclk_oe == 1, "R2 clock drive", sclk_oe, 1);
    for (int c = 0; c < lim; c++) begin
      if (busy) bcyc++;
      if (sclk_out != prev && sclk_out == ~idl) begin
        if (nb < 8) got[nb] = txd;
        nb++;
      end
      prev = sclk_out;
      if (inject && c == 3) begin wr_data = ~d; wr_en = 1; end
      else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    chk(got == d && nb == 8, "R1 bit order", got, d);
    chk(bcyc == 16 * eff_div(dv), "R2 busy length", bcyc, 16 * eff_div(dv));
    chk(irq_cnt == i0 + 1, "R5 one irq", irq_cnt - i0, 1);
    chk(done_flag == 1 && busy == 0, "R5 done", done_flag, 1);
    chk(txd == d[7], "R8 hold last bit", txd, d[7]);
    chk(sclk_out == idl, "R3 rest level", sclk_out, idl);
    if (inject) chk(wr_err == 1, "R7 error flag", wr_err, 1);
  endtask

  task automatic xfer_in(input logic [7:0] d, input bit ef, input bit inject);
    logic [7:0] got = 0;
    int i0 = irq_cnt;
    logic idl = ~ef;
    @(negedge clk);
    clk_out_mode = 0; edge_fall = ef; sclk_in = idl;
    repeat (4) @(negedge clk);
    chk(sclk_oe == 0, "R4 clock input", sclk_oe, 0);
    wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    for (int k = 0; k < 8; k++) begin
      sclk_in = ~idl;
      if (inject && k == 3) begin wr_data = ~d; wr_en = 1; end
      @(negedge clk); wr_en = 0;
      repeat (3) @(negedge clk);
      got[k] = txd;
      sclk_in = idl;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(got == d, "R4 external shift", got, d);
    chk(irq_cnt == i0 + 1, "R5 one irq ext", irq_cnt - i0, 1);
    chk(done_flag == 1 && busy == 0, "R5 done ext", done_flag, 1);
    chk(txd == d[7], "R8 hold last bit ext", txd, d[7]);
    if (inject) chk(wr_err == 1, "R7 error flag ext", wr_err, 1);
  endtask

  task automatic pulse_clr();
    clr_flag = 1; @(negedge clk); clr_flag = 0; @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(txd == 1, "R8 reset txd", txd, 1);
    chk(busy == 0 && done_flag == 0 && wr_err == 0 && irq == 0, "R8 reset flags",
        {busy, done_flag, wr_err, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sclk_out == 1, "R8 reset clock level", sclk_out, 1);

    xfer_out(8'hA5, 0, 8'd0, 0);
    xfer_out(8'h01, 1, 8'd1, 0);
    xfer_out(8'h80, 0, 8'd3, 0);
    xfer_in(8'h3C, 0, 0);
    xfer_in(8'hC3, 1, 0);

    repeat (10) @(negedge clk);
    chk(done_flag == 1, "R6 sticky done", done_flag, 1);
    pulse_clr();
    chk(done_flag == 0, "R6 clear done", done_flag, 0);

    xfer_out(8'h5A, 1, 8'd4, 1);
    pulse_clr();
    chk(wr_err == 0, "R7 clear error", wr_err, 0);
    xfer_in(8'h96, 0, 1);
    pulse_clr();

    xfer_out(8'h11, 0, 8'd2, 0);
    @(negedge clk);
    wr_data = 8'h22; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk(done_flag == 0, "R6 write clears done", done_flag, 0);
    while (busy) @(negedge clk);
    @(negedge clk);

    for (int n = 0; n < 12; n++) begin
      logic [7:0] d = 8'($urandom);
      bit ef = 1'($urandom);
      if (1'($urandom)) xfer_out(d, ef, 8'($urandom_range(0, 5)), 0);
      else xfer_in(d, ef, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule